// File: doc/BRIEF.md
# Repeating Multiframe-Aligned Message Transmitter

This block sends a fixed, unformatted data-link message of 1 to 64 bytes over and over on a serial link bit. A processor fills a shadow buffer one byte at a time. It then commits the buffer with a length. The committed message becomes the pending message. At a multiframe boundary the pending message is swapped into the active buffer, and the active message then loops with no gap until a later commit replaces it. A neighbouring bit selector pulls one link bit per request strobe. Before the first commit, and while a finished message waits for its replacement to start, the link bit is held at idle ones.

Message starts line up with the transmit multiframe. A local frame counter counts frame ticks, and a multiframe-start pulse resynchronises it. The counter sets an alignment period of 24 frames in T1 mode and 16 frames in E1 mode. A replacement never cuts the active message short. The current pass runs to its last bit, and the new message begins at the next alignment boundary after that.

Top module: `mfmsg_repeat_tx`

## Requirements
- R1: The length is committed as `commit_len_m1`, where value n means n+1 bytes (1 to 64). The active message sends buffer bytes 0 to n in address order, and after byte n it continues with byte 0.
- R2: Within each byte, bits go out least significant bit first. `tx_bit` shows the current bit, and each `bit_req` pulse advances to the next bit on the following cycle. Without a request the position holds.
- R3: The alignment period is 24 frames when `t1_mode`=1 and 16 frames when `t1_mode`=0. A `frame_tick` with `mf_start` high is a boundary and restarts the count. Without `mf_start`, the boundary is the 24th (T1) or 16th (E1) tick after the previous boundary.
- R4: A message starts only at a boundary. In the cycle after the boundary, `tx_bit` carries bit 0 of byte 0.
- R5: A commit made while a message is active takes effect only after the active pass completes its last bit. From then until the next boundary, `tx_bit` is 1, and the next message starts at that boundary.
- R6: With nothing pending, the active message repeats back to back with no idle bits. Boundaries and frame ticks do not restart it.
- R7: Until the first message has started, `tx_bit` is 1 whatever `bit_req`, `frame_tick` and `mf_start` do.
- R8: Byte writes go to the shadow buffer only. They do not change the bits of the active message.
- R9: If several commits happen before a swap, the latest commit's length and the latest shadow contents are what start.
- R10: After reset, `tx_bit` is 1 and no message is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t1_mode | input | 1 | 1: 24-frame alignment, 0: 16-frame alignment |
| frame_tick | input | 1 | One-cycle pulse at each transmit frame start |
| mf_start | input | 1 | Qualifies frame_tick as the start of an alignment period |
| wr_en | input | 1 | Shadow buffer byte write strobe |
| wr_addr | input | 6 | Shadow buffer byte address |
| wr_data | input | 8 | Shadow buffer byte value |
| commit | input | 1 | Marks the shadow buffer pending with commit_len_m1 |
| commit_len_m1 | input | 6 | Message length minus one |
| bit_req | input | 1 | Bit selector request to advance one link bit |
| tx_bit | output | 1 | Serial link bit |

## Verification
The hardest state to reach is a replacement that waits. A commit has to land mid-pass, and the active pass then has to run to completion while the shadow is being rewritten. Only after that does the idle gap open, and it must last until a boundary. The stimulus tracks the pass position in the bench and drains exactly the remaining bits. It then probes the ones gap and counts frame ticks up to the boundary, so that the period is exercised in both modes. A length sweep over every value from 1 to 64 repeats this handover for each length.

// File: rtl/mfmsg_pkg.sv
package mfmsg_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mfmsg_timebase.sv
module mfmsg_timebase #(
  parameter int FR_T1 = 24,
  parameter int FR_E1 = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic t1_mode,
  input  logic frame_tick,
  input  logic mf_start,
  output logic boundary
);
  localparam int FR_MAX = (FR_T1 > FR_E1) ? FR_T1 : FR_E1;
  localparam int CW = $clog2(FR_MAX);
  localparam logic [CW-1:0] LAST_T1 = CW'(FR_T1 - 1);
  localparam logic [CW-1:0] LAST_E1 = CW'(FR_E1 - 1);

  logic [CW-1:0] cnt_q, cnt_d, last_frame;
  logic          cnt_en;

  always_comb begin
    last_frame = t1_mode ? LAST_T1 : LAST_E1;
    boundary   = frame_tick & (mf_start | (cnt_q >= last_frame));
    cnt_en     = frame_tick;
    cnt_d      = boundary ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_FRAME_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < FR_MAX); // R3
  AST_CNT_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/mfmsg_store.sv
module mfmsg_store #(
  parameter int MAX_BYTES = 64,
  parameter int BYTE_W    = 8
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic                         wr_bank,
  input  logic [$clog2(MAX_BYTES)-1:0] wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic                         rd_bank,
  input  logic [$clog2(MAX_BYTES)-1:0] rd_addr,
  output logic [BYTE_W-1:0]            rd_data
);
  localparam int NBANK = 2;

  logic [BYTE_W-1:0] bank_rd [NBANK];
  logic              addr_ok;

  always_comb addr_ok = int'(wr_addr) < MAX_BYTES;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BYTE_W-1:0] mem [MAX_BYTES];
    logic              we;
    always_comb we = wr_en & addr_ok & (wr_bank == 1'(b));
    always_ff @(posedge clk) begin
      if (we) mem[wr_addr] <= wr_data;
    end
    always_comb bank_rd[b] = mem[rd_addr];
  end

  always_comb rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/mfmsg_seq.sv
module mfmsg_seq
  import mfmsg_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int BYTE_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [$clog2(MAX_BYTES)-1:0] commit_len_m1,
  input  logic                         boundary,
  input  logic                         bit_req,
  input  logic [BYTE_W-1:0]            rd_byte,
  output logic                         act_bank,
  output logic [$clog2(MAX_BYTES)-1:0] byte_ptr,
  output logic                         tx_bit
);
  localparam int AW = $clog2(MAX_BYTES);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  seq_state_e    state_q, state_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] pend_len_q, pend_len_d;
  logic [AW-1:0] act_len_q, act_len_d;
  logic          bank_q, bank_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          run, at_end, swap;

  always_comb begin
    run    = (state_q == ST_RUN);
    at_end = (ptr_q == act_len_q) && (bit_q == LAST_BIT);
    swap   = !run && pend_q && boundary;

    state_d   = state_q;
    act_len_d = act_len_q;
    bank_d    = bank_q;
    ptr_d     = ptr_q;
    bit_d     = bit_q;

    if (swap) begin
      state_d   = ST_RUN;
      bank_d    = ~bank_q;
      act_len_d = pend_len_q;
      ptr_d     = '0;
      bit_d     = '0;
    end else if (run && bit_req) begin
      if (at_end) begin
        ptr_d = '0;
        bit_d = '0;
        if (pend_q) state_d = ST_HOLD;
      end else if (bit_q == LAST_BIT) begin
        bit_d = '0;
        ptr_d = ptr_q + AW'(1);
      end else begin
        bit_d = bit_q + BW'(1);
      end
    end

    pend_d     = commit | (pend_q & ~swap);
    pend_len_d = commit ? commit_len_m1 : pend_len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HOLD;
      pend_q     <= 1'b0;
      pend_len_q <= '0;
      act_len_q  <= '0;
      bank_q     <= 1'b0;
      ptr_q      <= '0;
      bit_q      <= '0;
    end else begin
      state_q    <= state_d;
      pend_q     <= pend_d;
      pend_len_q <= pend_len_d;
      act_len_q  <= act_len_d;
      bank_q     <= bank_d;
      ptr_q      <= ptr_d;
      bit_q      <= bit_d;
    end
  end

  always_comb begin
    act_bank = bank_q;
    byte_ptr = ptr_q;
    tx_bit   = run ? rd_byte[bit_q] : 1'b1;
  end

  AST_PTR_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ptr_q <= act_len_q)); // R1
  AST_POS_HOLDS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(bit_req)) |-> ($stable(ptr_q) && $stable(bit_q))); // R2
  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> $past(boundary)); // R4
  AST_START_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> (ptr_q == '0 && bit_q == '0)); // R4
  AST_STOP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(run)) |-> $past(bit_req && at_end && pend_q)); // R5
endmodule

// File: rtl/mfmsg_repeat_tx.sv
module mfmsg_repeat_tx #(
  parameter int MAX_BYTES = 64,
  parameter int BYTE_W    = 8,
  parameter int FR_T1     = 24,
  parameter int FR_E1     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       t1_mode,
  input  logic       frame_tick,
  input  logic       mf_start,
  input  logic       wr_en,
  input  logic [5:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       commit,
  input  logic [5:0] commit_len_m1,
  input  logic       bit_req,
  output logic       tx_bit
);
  localparam int AW = $clog2(MAX_BYTES);

  logic          boundary;
  logic          act_bank;
  logic [AW-1:0] byte_ptr;
  logic [BYTE_W-1:0] rd_byte;

  mfmsg_timebase #(.FR_T1(FR_T1), .FR_E1(FR_E1)) u_tb (
    .clk(clk), .rst_n(rst_n), .t1_mode(t1_mode),
    .frame_tick(frame_tick), .mf_start(mf_start), .boundary(boundary)
  );

  mfmsg_store #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(~act_bank),
    .wr_addr(AW'(wr_addr)), .wr_data(BYTE_W'(wr_data)),
    .rd_bank(act_bank), .rd_addr(byte_ptr), .rd_data(rd_byte)
  );

  mfmsg_seq #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .commit_len_m1(AW'(commit_len_m1)), .boundary(boundary),
    .bit_req(bit_req), .rd_byte(rd_byte), .act_bank(act_bank),
    .byte_ptr(byte_ptr), .tx_bit(tx_bit)
  );
endmodule

// File: tb/tb_mfmsg_repeat_tx.sv
module tb_mfmsg_repeat_tx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, t1_mode, frame_tick, mf_start, wr_en, commit, bit_req;
  logic [5:0] wr_addr, commit_len_m1;
  logic [7:0] wr_data;
  logic       tx_bit;

  mfmsg_repeat_tx dut (
    .clk(clk), .rst_n(rst_n), .t1_mode(t1_mode), .frame_tick(frame_tick),
    .mf_start(mf_start), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_len_m1(commit_len_m1), .bit_req(bit_req),
    .tx_bit(tx_bit)
  );

  int n_chk = 0, n_fail = 0;
  int act_len = 1, act_seed = 0, pos = 0;
  bit done = 0;

  function automatic logic [7:0] byte_val(int seed, int i);
    logic [7:0] v;
    v = 8'(seed * 29 + i * 53 + 7);
    if (i == 0) v[0] = 1'b0;
    return v;
  endfunction

  function automatic logic exp_bit(int seed, int p);
    logic [7:0] b;
    b = byte_val(seed, p / 8);
    return b[p % 8];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tx_bit=%0b expected %0b (pos %0d)", tag, act, exp, pos);
    end
  endtask

  task automatic pulse_req();
    bit_req = 1'b1;
    @(negedge clk);
    bit_req = 1'b0;
  endtask

  task automatic tick(logic mf);
    frame_tick = 1'b1;
    mf_start   = mf;
    @(negedge clk);
    frame_tick = 1'b0;
    mf_start   = 1'b0;
  endtask

  task automatic load(int len, int seed);
    for (int i = 0; i < len; i++) begin
      wr_en = 1'b1; wr_addr = 6'(i); wr_data = byte_val(seed, i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    commit = 1'b1; commit_len_m1 = 6'(len - 1);
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic send(string tag);
    check(tag, tx_bit, exp_bit(act_seed, pos));
    pulse_req();
    pos = (pos + 1) % (8 * act_len);
  endtask

  task automatic finish_pass(string tag);
    int r;
    r = (pos == 0) ? 8 * act_len : 8 * act_len - pos;
    repeat (r) send(tag);
  endtask

  task automatic begin_msg(int len, int seed);
    act_len = len; act_seed = seed; pos = 0;
  endtask

  initial begin
    rst_n = 1'b0; t1_mode = 1'b1; frame_tick = 1'b0; mf_start = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; commit = 1'b0;
    commit_len_m1 = '0; bit_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset idle", tx_bit, 1'b1);

    // R7: no message yet, all stimulus leaves idle ones
    for (int k = 0; k < 30; k++) begin
      check("R7 idle before commit", tx_bit, 1'b1);
      if (k % 3 == 0) tick(1'b1); else if (k % 3 == 1) tick(1'b0); else pulse_req();
    end

    // R3 T1 period: resync, commit, count 24 ticks to boundary
    tick(1'b1);
    load(3, 1);
    for (int k = 1; k <= 24; k++) begin
      check("R3 T1 wait ones", tx_bit, 1'b1);
      tick(1'b0);
    end
    begin_msg(3, 1);
    check("R4 first bit after boundary", tx_bit, 1'b0);

    // R2/R6: repetition with frame ticks and boundaries in between
    repeat (20) send("R2 lsb first");
    tick(1'b1);
    tick(1'b0);
    repeat (40) send("R6 continuous repeat");

    // R8: rewrite shadow while active, active bits unchanged
    load(5, 2);
    finish_pass("R8 active unaffected");
    check("R5 gap ones", tx_bit, 1'b1);
    pulse_req();
    check("R5 gap ones", tx_bit, 1'b1);
    tick(1'b1);
    begin_msg(5, 2);
    repeat (48) send("R1 five byte message");

    // R3 E1 period: counter is at frame 0 after the last boundary
    t1_mode = 1'b0;
    load(4, 3);
    finish_pass("R5 finish pass");
    for (int k = 1; k <= 16; k++) begin
      check("R3 E1 wait ones", tx_bit, 1'b1);
      tick(1'b0);
    end
    begin_msg(4, 3);
    repeat (40) send("R3 E1 start");

    // R9: second commit before swap wins
    load(6, 4);
    load(2, 5);
    finish_pass("R9 finish pass");
    check("R9 gap ones", tx_bit, 1'b1);
    tick(1'b1);
    begin_msg(2, 5);
    repeat (48) send("R9 latest commit");

    // R1 sweep over every length
    for (int len = 1; len <= 64; len++) begin
      t1_mode = len[0];
      load(len, len + 10);
      finish_pass("R5 sweep finish");
      check("R5 sweep gap", tx_bit, 1'b1);
      tick(1'b1);
      begin_msg(len, len + 10);
      repeat (8 * len + 8) send("R1 length sweep");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 180000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule